// File: doc/BRIEF.md
# DMA List Element Sequencer

This block walks a scatter/gather list that software has placed in local store and turns each list entry into one transfer request for a downstream data mover. A command supplies the local-store address and byte length of the list, the local-store buffer address, the upper 32 bits of the effective address, a tag group number and an addressing mode (64-bit or 32-bit). The sequencer reads one 8-byte entry at a time and checks it. It hands the legal entries to the mover over a request/done handshake, one entry in flight at a time.

Entries may ask the sequencer to pause after their transfer. The pause is reported as a bit for the command's tag group in a stall status vector, and a resume pulse continues the walk. A malformed entry stops the list with a fault code. The progress registers (list pointer, remaining list bytes, local-store pointer, current entry size, upper address word) stay visible on debug outputs, so the offending entry can be located after a fault.

Top module: `dlist_walker`

## Requirements
- R1: A list entry is a 64-bit word: bit 63 is the pause flag, bits 62:48 are reserved and have no effect, bits 47:32 are the byte count and bits 31:0 are the low effective address. The request address is the command's upper word concatenated with the entry's low address.
- R2: Entries are processed in list order, one request at a time. Each finished entry moves the list pointer up by 8, lowers the remaining list bytes by 8 and moves the local-store pointer up by the entry's byte count (modulo 2^LS_AW). The low 3 bits of the command's list address and list length are taken as zero.
- R3: The request stays asserted, with its address, local-store address and size unchanged, until the mover's done pulse arrives.
- R4: Legal byte counts are 0, 1, 2, 4, 8, and multiples of 16 up to 16384. Any other count stops the list with fault code 1. A count of 0 is legal and issues no request.
- R5: An entry with a count below 16 must have a low address that is a multiple of its count. An entry with a count of 16 or more needs a 16-byte aligned low address. A violation stops the list with fault code 2.
- R6: In 64-bit mode, an entry whose last byte lies beyond the 4 GB region of its first byte (low address + count > 2^32) stops the list with fault code 3. An entry that ends exactly at the boundary is legal. In 32-bit mode this check is off.
- R7: A fault is reported in priority size over alignment over crossing. It issues no request for that entry. The list pointer and remaining bytes then still refer to the offending entry, the current size shows its full count, and the local-store pointer shows the position after the last finished entry. The fault code holds until the next command.
- R8: After an entry with the pause flag set completes, the sequencer stalls, sets stall status bit [tag] and fetches nothing more until resumed.
- R9: A resume pulse while stalled clears the tag's stall bit and continues with the next entry, or completes the list if none remain. A resume pulse at any other time has no effect.
- R10: When the remaining list bytes reach 0, list_done pulses for one cycle with done_tag equal to the command's tag, and busy falls. A command with a list length of 0 completes at once.
- R11: A command start is accepted only when idle or faulted. While the list is being walked or is stalled, a start pulse is ignored.
- R12: After reset the block is idle: no request, no fetch, stall status 0, fault code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse for a new list command |
| cmd_list_addr | input | LS_AW | Local-store byte address of the list |
| cmd_list_size | input | LS_AW | List length in bytes |
| cmd_ls_addr | input | LS_AW | Local-store buffer start address |
| cmd_ea_hi | input | 32 | Upper effective address word |
| cmd_tag | input | TAG_W | Tag group of the command |
| cmd_mode64 | input | 1 | 1 = 64-bit mode (crossing check on) |
| resume | input | 1 | Continue after a stall |
| ls_rd_en | output | 1 | Local-store entry read strobe |
| ls_rd_addr | output | LS_AW | Local-store entry read address |
| ls_rd_data | input | 64 | Entry word, valid the cycle after the strobe |
| xfer_req | output | 1 | Transfer request to the mover |
| xfer_ea | output | 64 | Effective address of the transfer |
| xfer_ls_addr | output | LS_AW | Local-store address of the transfer |
| xfer_size | output | 16 | Transfer byte count |
| xfer_done | input | 1 | Mover completion pulse |
| busy | output | 1 | Command in progress (including stalled) |
| stalled | output | 1 | Waiting for resume |
| list_done | output | 1 | One-cycle list completion pulse |
| done_tag | output | TAG_W | Tag of the completed command |
| fault_code | output | 2 | 0 none, 1 size, 2 alignment, 3 crossing |
| stall_status | output | 2^TAG_W | Stall bit per tag group |
| dbg_list_addr | output | LS_AW | Current list pointer |
| dbg_list_size | output | LS_AW | Remaining list bytes |
| dbg_ls_addr | output | LS_AW | Current local-store pointer |
| dbg_size | output | 16 | Count of the current entry (0 between entries) |
| dbg_ea_hi | output | 32 | Upper effective address word in use |

## Verification
The assertions assume that the mover raises xfer_done only while a request is pending and only for one cycle. They also assume that the entry word is valid in the cycle after the read strobe. The bench's mover and memory model are built to honour both: done is a single-cycle pulse, sent a fixed number of cycles after a request is first seen, and the read data is set half a cycle after the strobe. Random lists use aligned legal entries most of the time. Mis-sized, misaligned and boundary-crossing entries are injected on purpose, so every fault path is reached without breaking these input assumptions.

// File: rtl/dlist_pkg.sv
package dlist_pkg;

    localparam int ENTRY_BYTES = 8;
    localparam int SIZE_W      = 16;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_SIZE  = 2'd1,
        FLT_ALIGN = 2'd2,
        FLT_CROSS = 2'd3
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_XFER,
        ST_STALL,
        ST_FAULT
    } st_e;

    typedef struct packed {
        logic              pause;
        logic [14:0]       rsvd;
        logic [SIZE_W-1:0] size;
        logic [31:0]       ea_lo;
    } entry_t;

    // Counts below 16 that are legal on their own.
    function automatic logic small_legal(logic [SIZE_W-1:0] sz);
        return (sz == 16'd0) || (sz == 16'd1) || (sz == 16'd2) ||
               (sz == 16'd4) || (sz == 16'd8);
    endfunction

    // Low-address bits that must be zero for a given count.
    function automatic logic [31:0] align_mask(logic [SIZE_W-1:0] sz);
        if (sz >= 16'd16)
            return 32'h0000_000F;
        else if (sz == 16'd0)
            return 32'h0;
        else
            return {16'h0, sz - 16'd1};
    endfunction

endpackage

// File: rtl/dlist_entry_check.sv
module dlist_entry_check
    import dlist_pkg::*;
#(
    parameter int MAX_XFER = 16384
) (
    input  entry_t entry,
    input  logic   mode64,
    output flt_e   code
);
    logic        size_ok;
    logic        align_ok;
    logic [32:0] end_sum;
    logic        crosses;

    always_comb begin
        size_ok  = small_legal(entry.size) ||
                   ((entry.size[3:0] == 4'd0) && (32'(entry.size) <= MAX_XFER));
        align_ok = ((entry.ea_lo & align_mask(entry.size)) == 32'h0);
        end_sum  = {1'b0, entry.ea_lo} + {17'h0, entry.size};
        crosses  = mode64 && end_sum[32] && (end_sum[31:0] != 32'h0);

        if (!size_ok)
            code = FLT_SIZE;
        else if (!align_ok)
            code = FLT_ALIGN;
        else if (crosses)
            code = FLT_CROSS;
        else
            code = FLT_NONE;
    end
endmodule

// File: rtl/dlist_stall_bank.sv
module dlist_stall_bank #(
    parameter int TAG_W = 5,
    localparam int NTAG = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] idx,
    output logic [NTAG-1:0]  bits
);
    for (genvar g = 0; g < NTAG; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits[g] <= 1'b0;
            else if (set_en && (idx == TAG_W'(g)))
                bits[g] <= 1'b1;
            else if (clr_en && (idx == TAG_W'(g)))
                bits[g] <= 1'b0;
        end
    end

    assert_set_R8: assert property (@(posedge clk) disable iff (rst)
        set_en |=> bits[$past(idx)]);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> !bits[$past(idx)]);
endmodule

// File: rtl/dlist_walker.sv
module dlist_walker
    import dlist_pkg::*;
#(
    parameter int LS_AW    = 18,
    parameter int TAG_W    = 5,
    parameter int MAX_XFER = 16384,
    localparam int NTAG    = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [LS_AW-1:0]  cmd_list_addr,
    input  logic [LS_AW-1:0]  cmd_list_size,
    input  logic [LS_AW-1:0]  cmd_ls_addr,
    input  logic [31:0]       cmd_ea_hi,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic              cmd_mode64,
    input  logic              resume,
    output logic              ls_rd_en,
    output logic [LS_AW-1:0]  ls_rd_addr,
    input  logic [63:0]       ls_rd_data,
    output logic              xfer_req,
    output logic [63:0]       xfer_ea,
    output logic [LS_AW-1:0]  xfer_ls_addr,
    output logic [15:0]       xfer_size,
    input  logic              xfer_done,
    output logic              busy,
    output logic              stalled,
    output logic              list_done,
    output logic [TAG_W-1:0]  done_tag,
    output logic [1:0]        fault_code,
    output logic [NTAG-1:0]   stall_status,
    output logic [LS_AW-1:0]  dbg_list_addr,
    output logic [LS_AW-1:0]  dbg_list_size,
    output logic [LS_AW-1:0]  dbg_ls_addr,
    output logic [15:0]       dbg_size,
    output logic [31:0]       dbg_ea_hi
);
    localparam logic [LS_AW-1:0] STEP = LS_AW'(ENTRY_BYTES);

    st_e               st;
    entry_t            entry_q;
    entry_t            entry_in;
    entry_t            cur_entry;
    flt_e              chk_code;
    flt_e              fault_q;
    logic [LS_AW-1:0]  list_addr;
    logic [LS_AW-1:0]  list_left;
    logic [LS_AW-1:0]  ls_ptr;
    logic [15:0]       cur_size;
    logic [31:0]       ea_hi_q;
    logic [TAG_W-1:0]  tag_q;
    logic              mode64_q;
    logic              done_q;
    logic              finish;
    logic              last_entry;
    logic              can_start;

    assign entry_in = entry_t'(ls_rd_data);

    dlist_entry_check #(.MAX_XFER(MAX_XFER)) u_check (
        .entry  (entry_in),
        .mode64 (mode64_q),
        .code   (chk_code)
    );

    always_comb begin
        cur_entry  = (st == ST_DECODE) ? entry_in : entry_q;
        finish     = ((st == ST_DECODE) && (chk_code == FLT_NONE) &&
                      (entry_in.size == 16'd0)) ||
                     ((st == ST_XFER) && xfer_done);
        last_entry = (list_left == STEP);
        can_start  = (st == ST_IDLE) || (st == ST_FAULT);
    end

    dlist_stall_bank #(.TAG_W(TAG_W)) u_stall (
        .clk    (clk),
        .rst    (rst),
        .set_en (finish && cur_entry.pause),
        .clr_en ((st == ST_STALL) && resume),
        .idx    (tag_q),
        .bits   (stall_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            entry_q   <= '0;
            fault_q   <= FLT_NONE;
            list_addr <= '0;
            list_left <= '0;
            ls_ptr    <= '0;
            cur_size  <= '0;
            ea_hi_q   <= '0;
            tag_q     <= '0;
            mode64_q  <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE, ST_FAULT: begin
                    if (cmd_start) begin
                        list_addr <= {cmd_list_addr[LS_AW-1:3], 3'b000};
                        list_left <= {cmd_list_size[LS_AW-1:3], 3'b000};
                        ls_ptr    <= cmd_ls_addr;
                        ea_hi_q   <= cmd_ea_hi;
                        tag_q     <= cmd_tag;
                        mode64_q  <= cmd_mode64;
                        fault_q   <= FLT_NONE;
                        cur_size  <= '0;
                        if (cmd_list_size[LS_AW-1:3] == '0) begin
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            st <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: st <= ST_DECODE;
                ST_DECODE: begin
                    entry_q <= entry_in;
                    if (chk_code != FLT_NONE) begin
                        fault_q  <= chk_code;
                        cur_size <= entry_in.size;
                        st       <= ST_FAULT;
                    end else if (entry_in.size != 16'd0) begin
                        cur_size <= entry_in.size;
                        st       <= ST_XFER;
                    end
                end
                ST_XFER: ;
                ST_STALL: begin
                    if (resume) begin
                        if (list_left == '0) begin
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            st <= ST_FETCH;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase

            if (finish) begin
                list_addr <= list_addr + STEP;
                list_left <= list_left - STEP;
                ls_ptr    <= ls_ptr + LS_AW'(cur_entry.size);
                cur_size  <= '0;
                if (cur_entry.pause) begin
                    st <= ST_STALL;
                end else if (last_entry) begin
                    done_q <= 1'b1;
                    st     <= ST_IDLE;
                end else begin
                    st <= ST_FETCH;
                end
            end
        end
    end

    assign ls_rd_en      = (st == ST_FETCH);
    assign ls_rd_addr    = list_addr;
    assign xfer_req      = (st == ST_XFER);
    assign xfer_ea       = {ea_hi_q, entry_q.ea_lo};
    assign xfer_ls_addr  = ls_ptr;
    assign xfer_size     = entry_q.size;
    assign busy          = !can_start;
    assign stalled       = (st == ST_STALL);
    assign list_done     = done_q;
    assign done_tag      = tag_q;
    assign fault_code    = fault_q;
    assign dbg_list_addr = list_addr;
    assign dbg_list_size = list_left;
    assign dbg_ls_addr   = ls_ptr;
    assign dbg_size      = cur_size;
    assign dbg_ea_hi     = ea_hi_q;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_done) |=>
            (xfer_req && $stable(xfer_ea) && $stable(xfer_size) && $stable(xfer_ls_addr)));

    assert_req_size_R4: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> (xfer_size != 16'd0 && 32'(xfer_size) <= MAX_XFER));

    assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && xfer_done) |=> (dbg_list_addr == $past(dbg_list_addr) + STEP));

    assert_done_empty_R10: assert property (@(posedge clk) disable iff (rst)
        list_done |-> (dbg_list_size == '0 && !busy));

    assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 2'd0) |-> (!xfer_req && !ls_rd_en));
endmodule

// File: tb/dlist_walker_test.sv
module dlist_walker_test;
    localparam int LS_AW = 18;
    localparam int TAG_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              cmd_start = 0;
    logic [LS_AW-1:0]  cmd_list_addr = 0, cmd_list_size = 0, cmd_ls_addr = 0;
    logic [31:0]       cmd_ea_hi = 0;
    logic [TAG_W-1:0]  cmd_tag = 0;
    logic              cmd_mode64 = 0;
    logic              resume = 0;
    logic              ls_rd_en;
    logic [LS_AW-1:0]  ls_rd_addr;
    logic [63:0]       ls_rd_data;
    logic              xfer_req;
    logic [63:0]       xfer_ea;
    logic [LS_AW-1:0]  xfer_ls_addr;
    logic [15:0]       xfer_size;
    logic              xfer_done;
    logic              busy, stalled, list_done;
    logic [TAG_W-1:0]  done_tag;
    logic [1:0]        fault_code;
    logic [31:0]       stall_status;
    logic [LS_AW-1:0]  dbg_list_addr, dbg_list_size, dbg_ls_addr;
    logic [15:0]       dbg_size;
    logic [31:0]       dbg_ea_hi;

    dlist_walker #(.LS_AW(LS_AW), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_list_addr(cmd_list_addr),
        .cmd_list_size(cmd_list_size), .cmd_ls_addr(cmd_ls_addr), .cmd_ea_hi(cmd_ea_hi),
        .cmd_tag(cmd_tag), .cmd_mode64(cmd_mode64), .resume(resume),
        .ls_rd_en(ls_rd_en), .ls_rd_addr(ls_rd_addr), .ls_rd_data(ls_rd_data),
        .xfer_req(xfer_req), .xfer_ea(xfer_ea), .xfer_ls_addr(xfer_ls_addr),
        .xfer_size(xfer_size), .xfer_done(xfer_done), .busy(busy), .stalled(stalled),
        .list_done(list_done), .done_tag(done_tag), .fault_code(fault_code),
        .stall_status(stall_status), .dbg_list_addr(dbg_list_addr),
        .dbg_list_size(dbg_list_size), .dbg_ls_addr(dbg_ls_addr),
        .dbg_size(dbg_size), .dbg_ea_hi(dbg_ea_hi)
    );

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] mem [0:255];
    logic [63:0] ent [0:31];
    logic [63:0] log_ea [0:63];
    logic [LS_AW-1:0] log_ls [0:63];
    logic [15:0] log_sz [0:63];
    int log_n = 0;
    int mover_lat = 3;
    int total_cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Mover stub and local-store read model.
    initial begin
        bit active = 0;
        int cnt = 0;
        xfer_done = 0;
        ls_rd_data = 0;
        forever begin
            @(negedge clk);
            if (ls_rd_en) ls_rd_data = mem[ls_rd_addr[10:3]];
            if (xfer_done) begin
                xfer_done = 0;
                active = 0;
            end else if (xfer_req && !active) begin
                if (log_n < 64) begin
                    log_ea[log_n] = xfer_ea;
                    log_ls[log_n] = xfer_ls_addr;
                    log_sz[log_n] = xfer_size;
                end
                log_n++;
                active = 1;
                cnt = mover_lat;
            end else if (active) begin
                cnt--;
                if (cnt <= 0) xfer_done = 1;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            total_cyc++;
            if (total_cyc > 150000) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog: actual %0d expected below 150000", total_cyc);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    function automatic int classify(logic [63:0] w, bit m64);
        int unsigned sz = int'(w[47:32]);
        longint unsigned lo = longint'(w[31:0]);
        bit legal = (sz == 0 || sz == 1 || sz == 2 || sz == 4 || sz == 8 ||
                     (sz % 16 == 0 && sz <= 16384));
        if (!legal) return 1;
        if (sz >= 16 && lo % 16 != 0) return 2;
        if (sz > 0 && sz < 16 && lo % sz != 0) return 2;
        if (m64 && lo + sz > 64'h1_0000_0000) return 3;
        return 0;
    endfunction

    function automatic logic [63:0] mk(bit p, int unsigned sz, logic [31:0] lo);
        return {p, 15'h0, sz[15:0], lo};
    endfunction

    task automatic run_list(input int base_w, input int n, input logic [LS_AW-1:0] ls0,
                            input logic [31:0] hi, input logic [TAG_W-1:0] tag,
                            input bit m64, input bit poke);
        logic [63:0] e_ea [0:31];
        logic [LS_AW-1:0] e_ls [0:31];
        logic [15:0] e_sz [0:31];
        int e_n = 0, fk = -1, fcode = 0, e_stalls = 0, stalls = 0, cyc = 0;
        logic [LS_AW-1:0] ls = ls0;
        for (int k = 0; k < n; k++) mem[base_w + k] = ent[k];
        for (int k = 0; k < n; k++) begin
            int c = classify(ent[k], m64);
            if (c != 0) begin fk = k; fcode = c; break; end
            if (ent[k][47:32] != 0) begin
                e_ea[e_n] = {hi, ent[k][31:0]};
                e_ls[e_n] = ls;
                e_sz[e_n] = ent[k][47:32];
                e_n++;
            end
            ls = ls + LS_AW'(ent[k][47:32]);
            if (ent[k][63]) e_stalls++;
        end
        log_n = 0;
        @(negedge clk);
        cmd_list_addr = LS_AW'(base_w * 8);
        cmd_list_size = LS_AW'(n * 8);
        cmd_ls_addr = ls0; cmd_ea_hi = hi; cmd_tag = tag; cmd_mode64 = m64;
        cmd_start = 1;
        @(negedge clk);
        cmd_start = 0;
        if (poke) begin
            repeat (3) @(negedge clk);
            cmd_list_addr = LS_AW'(12'h700); cmd_list_size = 8; cmd_ls_addr = 0;
            cmd_ea_hi = 32'hDEAD_0000; cmd_tag = tag + 1'b1;
            cmd_start = 1;
            @(negedge clk);
            cmd_start = 0;
        end
        while (1) begin
            if (list_done || fault_code != 0) break;
            if (stalled) begin
                int held = log_n;
                stalls++;
                chk(stall_status == (32'h1 << tag), "R8 stall bit", stall_status, 32'h1 << tag);
                repeat (12) @(negedge clk);
                chk(log_n == held && stalled, "R8 no progress while stalled", log_n, held);
                resume = 1;
                @(negedge clk);
                resume = 0;
                chk(stall_status == 0, "R9 stall bit cleared", stall_status, 0);
                continue;
            end
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                chk(0, "R10 list never ended", cyc, 0);
                return;
            end
        end
        chk(stalls == e_stalls, "R8 stall count", stalls, e_stalls);
        chk(log_n == e_n, "R2 request count", log_n, e_n);
        for (int k = 0; k < e_n && k < log_n; k++) begin
            chk(log_ea[k] == e_ea[k], "R1 request address", log_ea[k], e_ea[k]);
            chk(log_ls[k] == e_ls[k] && log_sz[k] == e_sz[k], "R2 request ls/size",
                {log_ls[k], log_sz[k]}, {e_ls[k], e_sz[k]});
        end
        chk(dbg_ls_addr == ls, "R2 final ls pointer", dbg_ls_addr, ls);
        if (fk < 0) begin
            chk(list_done && done_tag == tag, "R10 done tag", {list_done, done_tag}, {1'b1, tag});
            chk(dbg_list_addr == LS_AW'((base_w + n) * 8) && dbg_list_size == 0,
                "R2 list regs at end", {dbg_list_addr, dbg_list_size}, LS_AW'((base_w + n) * 8) << LS_AW);
            chk(dbg_ea_hi == hi, "R1 upper word", dbg_ea_hi, hi);
            @(negedge clk);
            chk(!list_done && !busy, "R10 single pulse", {list_done, busy}, 0);
        end else begin
            chk(fault_code == 2'(fcode), "R7 fault code", fault_code, fcode);
            chk(dbg_list_addr == LS_AW'((base_w + fk) * 8), "R7 list addr at fault",
                dbg_list_addr, LS_AW'((base_w + fk) * 8));
            chk(dbg_list_size == LS_AW'((n - fk) * 8), "R7 list size at fault",
                dbg_list_size, LS_AW'((n - fk) * 8));
            chk(dbg_size == ent[fk][47:32], "R7 bytes not moved", dbg_size, ent[fk][47:32]);
            repeat (5) @(negedge clk);
            chk(fault_code == 2'(fcode) && !xfer_req && log_n == e_n, "R7 fault holds",
                fault_code, fcode);
        end
    endtask

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !xfer_req && !ls_rd_en && stall_status == 0 && fault_code == 0,
            "R12 reset state", {busy, xfer_req, ls_rd_en, fault_code}, 0);

        // Plain three-entry list.
        ent[0] = mk(0, 16, 32'h1000_0080); ent[1] = mk(0, 128, 32'h2000_0100);
        ent[2] = mk(0, 8, 32'h3000_0008);
        run_list(0, 3, 18'h01000, 32'h0000_0004, 5'd3, 1, 0);

        // Pause flag in the middle (R8, R9).
        ent[0] = mk(0, 32, 32'h40); ent[1] = mk(1, 64, 32'h80); ent[2] = mk(0, 4, 32'h104);
        run_list(8, 3, 18'h02000, 32'h1, 5'd7, 1, 0);
        // Pause flag on the last entry.
        ent[0] = mk(0, 16, 32'h0); ent[1] = mk(1, 16, 32'h10);
        run_list(16, 2, 18'h00100, 32'h2, 5'd31, 0, 0);

        // R4: count of 24, then count above 16384.
        ent[0] = mk(0, 16, 32'h0); ent[1] = mk(0, 24, 32'h100); ent[2] = mk(0, 16, 32'h0);
        run_list(24, 3, 18'h00200, 32'h5, 5'd1, 1, 0);
        ent[0] = mk(0, 16400, 32'h0);
        run_list(32, 1, 18'h00300, 32'h5, 5'd1, 1, 0);

        // R5: misaligned large and small entries.
        ent[0] = mk(0, 32, 32'h1002_0088);
        run_list(40, 1, 18'h00400, 32'h0, 5'd2, 1, 0);
        ent[0] = mk(0, 8, 32'h10); ent[1] = mk(0, 4, 32'h12);
        run_list(48, 2, 18'h00500, 32'h0, 5'd2, 0, 0);

        // R6: crossing in 64-bit mode, allowed in 32-bit mode, exact end legal.
        ent[0] = mk(0, 512, 32'hFFFF_FF00);
        run_list(56, 1, 18'h00600, 32'h9, 5'd4, 1, 0);
        run_list(56, 1, 18'h00600, 32'h9, 5'd4, 0, 0);
        ent[0] = mk(0, 256, 32'hFFFF_FF00);
        run_list(60, 1, 18'h00600, 32'h9, 5'd4, 1, 0);

        // R1 reserved bits ignored, R4 zero-count entry skipped.
        ent[0] = {1'b0, 15'h7FFF, 16'd64, 32'h0000_0200};
        ent[1] = mk(0, 0, 32'h0000_0003);
        ent[2] = {1'b0, 15'h1234, 16'd2, 32'h0000_0006};
        run_list(64, 3, 18'h3FFF0, 32'hABCD_0000, 5'd9, 1, 0);

        // R10: empty list completes at once.
        run_list(72, 0, 18'h00010, 32'h3, 5'd12, 1, 0);

        // R11: start pulse during a walk is ignored.
        mover_lat = 20;
        ent[0] = mk(0, 16, 32'h0); ent[1] = mk(0, 32, 32'h20);
        run_list(80, 2, 18'h00700, 32'h6, 5'd5, 1, 1);
        mover_lat = 3;

        // R9: resume while idle has no effect.
        resume = 1;
        @(negedge clk);
        resume = 0;
        @(negedge clk);
        chk(!busy && stall_status == 0 && !xfer_req, "R9 idle resume ignored",
            {busy, stall_status}, 0);

        // Random lists.
        for (int t = 0; t < 12; t++) begin
            int n = 1 + int'($urandom % 6);
            for (int k = 0; k < n; k++) begin
                int unsigned sel = $urandom % 12;
                int unsigned sz;
                logic [31:0] lo = $urandom;
                case (sel)
                    0: sz = 0; 1: sz = 1; 2: sz = 2; 3: sz = 4; 4: sz = 8;
                    default: sz = 16 * (1 + ($urandom % 1024));
                endcase
                if (sz >= 16) lo[3:0] = 0;
                else if (sz > 1) lo = lo & ~(sz - 1);
                case ($urandom % 10)
                    0: sz = 24;
                    1: lo = lo | 32'h4;
                    2: begin sz = 16384; lo = 32'hFFFF_F000; end
                    default: ;
                endcase
                ent[k] = mk(($urandom % 5) == 0, sz, lo);
            end
            run_list(96 + t * 8, n, LS_AW'($urandom) & 18'h3FFF0, $urandom,
                     TAG_W'($urandom), bit'($urandom % 2), 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule